// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write single words in an asynchronous static RAM. The RAM has an 18-bit word address, a 24-bit data bus and three active-low controls: chip select, output enable and write strobe. A host hands over one request at a time through a valid/ready handshake carrying an address, a write flag and write data. The controller then plays out the pin sequence for that request on the memory side. A read ends with a one-cycle valid strobe and the captured word.

Every nanosecond limit of the memory is turned into a whole number of system clocks. Each limit is divided by the clock period, rounded up, and held to at least one cycle. The write strobe window, the read access window and the output float time after a read are therefore all met by counting. The data bus is split into an output word, an output-enable and an input word, so a pad cell outside the block can form the tri-state pin. The controller enables its drivers only while the write strobe is low and output enable is high. When a write follows a read, it holds output enable high for a turnaround period before it drives the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the chip select, output enable and write strobe are all high, the data drivers are off, rd_valid is low and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready falls in the cycle after acceptance and rises again in the cycle after the last cycle of the pin sequence. Requests presented while req_ready is low are ignored. The chip is deselected (chip select high) whenever req_ready is high.
- R3: A read drives chip select and output enable low and the write strobe high, with the request address on mem_addr. This starts in the cycle after acceptance and lasts RD_CYC cycles, where RD_CYC is the count of the 8 ns access time.
- R4: The edge that ends the read window captures mem_dq_in into rd_data and raises rd_valid for exactly one cycle. rd_data then holds until the next read completes.
- R5: A write holds chip select low, output enable high and the write strobe low for WP_CYC cycles, with the drivers on and mem_dq_out equal to the request data. The write strobe rises and the drivers turn off on the same edge, and the address and data stay stable for the whole strobe.
- R6: A write accepted when the previous operation was a read is preceded by TA_CYC cycles in which chip select is low and output enable, write strobe and the driver enable are all inactive.
- R7: A write accepted after a write, or after reset, lowers the write strobe in the cycle directly after acceptance.
- R8: Each count is max(1, ceil(limit / CLK_PS)). WP_CYC covers both the 5.5 ns strobe width and the 4 ns data setup, RD_CYC covers 8 ns, and TA_CYC covers 3.5 ns. At CLK_PS = 2500 these give WP_CYC = 3, RD_CYC = 4 and TA_CYC = 2.
- R9: The data drivers are never enabled while the write strobe is high or output enable is low.
- R10: At the memory pins, every write strobe lasts at least 5.5 ns, the data is stable at least 4 ns before the strobe rises, and the address is stable at least 5.5 ns before the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 24 | Write data |
| rd_valid | output | 1 | One-cycle strobe: rd_data is new |
| rd_data | output | 24 | Last word read |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 24 | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Enables the bus drivers |
| mem_dq_in | input | 24 | Data sampled from the memory bus |

## Verification
With a 10 ns clock, a read's pins change in the cycle after acceptance, and rd_valid and the word appear one edge later (RD_CYC = 1). A write lowers the strobe one edge after acceptance, or two edges after it when a turnaround comes first, and releases it one edge after that. The bench drives inputs on the falling edge and samples 1 ns after each rising edge, at exactly the edge these counts predict. A second instance runs with a 2.5 ns period setting, and the bench counts cycles per pin state to confirm the larger derived windows. A time-based memory model measures the strobe, setup and address windows in simulation time and keeps the stored words that reads are compared against.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_TURN  = 2'd2,
        ST_WRITE = 2'd3
    } asram_st_e;

    // Clock count covering a limit in ps, rounded up, never below one.
    function automatic int span_cycles(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    logic              valid_d, valid_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        valid_d = cap_en;
        data_d  = cap_en ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            data_q  <= data_d;
        end
    end

    assign valid = valid_q;
    assign dout  = data_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 24,
    parameter int CLK_PS   = 10000,
    parameter int T_WP_PS  = 5500,
    parameter int T_DW_PS  = 4000,
    parameter int T_AA_PS  = 8000,
    parameter int T_OHZ_PS = 3500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WP_CYC  = imax(span_cycles(T_WP_PS, CLK_PS), span_cycles(T_DW_PS, CLK_PS));
    localparam int RD_CYC  = span_cycles(T_AA_PS, CLK_PS);
    localparam int TA_CYC  = span_cycles(T_OHZ_PS, CLK_PS);
    localparam int CNT_MAX = imax(WP_CYC, imax(RD_CYC, TA_CYC));
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        asram_st_e         st;
        logic              was_rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_s;

    ctrl_s         cur_q, nxt_d;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_last;
    logic          cap_en;

    always_comb begin
        nxt_d    = cur_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cap_en   = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    cnt_load    = 1'b1;
                    if (req_write) begin
                        nxt_d.was_rd = 1'b0;
                        if (cur_q.was_rd) begin
                            nxt_d.st = ST_TURN;
                            cnt_val  = CW'(TA_CYC);
                        end else begin
                            nxt_d.st = ST_WRITE;
                            cnt_val  = CW'(WP_CYC);
                        end
                    end else begin
                        nxt_d.was_rd = 1'b1;
                        nxt_d.st     = ST_READ;
                        cnt_val      = CW'(RD_CYC);
                    end
                end
            end
            ST_READ: begin
                if (cnt_last) begin
                    cap_en   = 1'b1;
                    nxt_d.st = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (cnt_last) begin
                    nxt_d.st = ST_WRITE;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(WP_CYC);
                end
            end
            ST_WRITE: begin
                if (cnt_last) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, was_rd: 1'b0, addr: '0, wdata: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    asram_wait_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .valid  (rd_valid),
        .dout   (rd_data)
    );

    assign req_ready  = (cur_q.st == ST_IDLE);
    assign mem_ce_n   = (cur_q.st == ST_IDLE);
    assign mem_oe_n   = (cur_q.st != ST_READ);
    assign mem_we_n   = (cur_q.st != ST_WRITE);
    assign mem_dq_oe  = (cur_q.st == ST_WRITE);
    assign mem_addr   = cur_q.addr;
    assign mem_dq_out = cur_q.wdata;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    AST_DRV_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R9
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n); // R2
    AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4
    AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!mem_oe_n)); // R4
    AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> mem_we_n); // R6
    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_out) && $stable(mem_addr))); // R5
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // u0: default 10 ns setting, every count is one cycle
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [23:0] rd_data, mem_dq_out;
    logic [23:0] mem_dq_in;
    logic [17:0] mem_addr;

    asram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // u1: 2.5 ns setting, larger derived counts
    logic        v1 = 1'b0, w1 = 1'b0;
    logic        rdy1, rv1, ce1, oe1, we1, dqoe1;
    logic [23:0] rd1, dqo1;
    logic [17:0] a1;

    asram_ctrl #(.CLK_PS(2500)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(rdy1),
        .req_write(w1), .req_addr(18'h00005), .req_wdata(24'h777777),
        .rd_valid(rv1), .rd_data(rd1), .mem_addr(a1),
        .mem_ce_n(ce1), .mem_oe_n(oe1), .mem_we_n(we1),
        .mem_dq_out(dqo1), .mem_dq_oe(dqoe1), .mem_dq_in(24'h5A5A5A)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory model for u0 ----------------
    logic [23:0] mem [int];
    logic [23:0] sb  [int];
    real t_wef = 0.0, t_dat = 0.0, t_adr = 0.0;
    logic [23:0] cur_d = '0;

    always @(mem_addr, mem_ce_n, mem_oe_n, mem_we_n) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 24'h0;
        else
            mem_dq_in = 24'hEEEEEE;
    end
    always @(mem_addr) t_adr = $realtime;
    always @(mem_dq_out, mem_dq_oe) if (mem_dq_oe) begin cur_d = mem_dq_out; t_dat = $realtime; end
    always @(negedge mem_we_n) if (rst_n) t_wef = $realtime;
    always @(posedge mem_we_n) begin
        if (rst_n) begin
            check("R10 strobe width >= 5.5", 32'($realtime - t_wef >= 5.5), 1);
            check("R10 data setup >= 4", 32'($realtime - t_dat >= 4.0), 1);
            check("R10 address setup >= 5.5", 32'($realtime - t_adr >= 5.5), 1);
            mem[int'(mem_addr)] = cur_d;
        end
    end

    // contention / turnaround watch, sampled mid-cycle
    logic prev_rd = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && (mem_we_n || !mem_oe_n)) begin
                errors++; $display("FAIL R9 drivers on with we_n=%b oe_n=%b", mem_we_n, mem_oe_n);
            end
            if (prev_rd && !mem_we_n) begin
                errors++; $display("FAIL R6 strobe low right after read actual=0 expected=1");
            end
        end
        prev_rd = rst_n && !mem_oe_n;
    end

    // ---------------- operations ----------------
    bit last_rd = 1'b0;

    task automatic op(input logic wr, input logic [17:0] a, input logic [23:0] d);
        @(negedge clk);
        check("R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R2 ready low after accept", req_ready, 0);
        if (!wr) begin
            check("R3 read pins ce,oe,we", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
            check("R3 read address", mem_addr, a);
            @(posedge clk); #1;
            check("R4 rd_valid pulse", rd_valid, 1);
            check("R4 read data", rd_data, sb[int'(a)]);
            check("R2 ready back", req_ready, 1);
            @(posedge clk); #1;
            check("R4 rd_valid one cycle", rd_valid, 0);
            check("R4 read data held", rd_data, sb[int'(a)]);
            last_rd = 1'b1;
        end else begin
            if (last_rd) begin
                check("R6 turnaround ce,oe,we,oe_drv", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0110);
                @(posedge clk); #1;
            end else begin
                check("R7 strobe low next cycle", mem_we_n, 0);
            end
            check("R5 write pins ce,oe,we,oe_drv", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0101);
            check("R5 write data driven", mem_dq_out, d);
            check("R5 write address", mem_addr, a);
            @(posedge clk); #1;
            check("R5 strobe and drivers released", {mem_we_n, mem_dq_oe}, 2'b10);
            check("R2 ready after write", req_ready, 1);
            sb[int'(a)] = d;
            last_rd = 1'b0;
        end
    endtask

    // {write, addr[17:0], data[23:0]}
    localparam logic [42:0] VEC [0:9] = '{
        {1'b1, 18'h00001, 24'hABCDEF},
        {1'b1, 18'h3FFFF, 24'h123456},
        {1'b0, 18'h00001, 24'h000000},
        {1'b1, 18'h00010, 24'h0F0F0F},
        {1'b0, 18'h00010, 24'h000000},
        {1'b0, 18'h3FFFF, 24'h000000},
        {1'b1, 18'h00001, 24'hFFFFFF},
        {1'b1, 18'h00002, 24'h000000},
        {1'b0, 18'h00001, 24'h000000},
        {1'b0, 18'h00002, 24'h000000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int oe_cnt, rv_idx, ta_cnt, we_cnt;
        // R1 reset state
        #12;
        check("R1 reset pins ce,oe,we,oe_drv", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        check("R1 reset rd_valid, ready", {rd_valid, req_ready}, 2'b01);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 first cycle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);

        for (int i = 0; i < 10; i++)
            op(VEC[i][42], VEC[i][41:24], VEC[i][23:0]);

        // R2: request while busy is ignored
        op(1'b1, 18'h00007, 24'h5C5C5C);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00007;
        @(posedge clk); #1;
        req_write = 1'b1; req_wdata = 24'h999999;
        @(posedge clk); #1;
        check("R2 busy request not written", mem_we_n, 1);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check("R2 no strobe from ignored request", mem_we_n, 1);
        last_rd = 1'b1;
        op(1'b0, 18'h00007, 24'h0);

        // R8: derived counts at CLK_PS = 2500
        @(negedge clk); v1 = 1'b1; w1 = 1'b0;
        @(posedge clk); #1; v1 = 1'b0;
        oe_cnt = 0; rv_idx = -1;
        for (int k = 0; k < 10; k++) begin
            if (!oe1) oe_cnt++;
            if (rv1 && rv_idx < 0) begin rv_idx = k; check("R4 u1 read data", rd1, 24'h5A5A5A); end
            @(posedge clk); #1;
        end
        check("R8 read window 4 cycles", oe_cnt, 4);
        check("R8 rd_valid after 4 cycles", rv_idx, 4);
        @(negedge clk); v1 = 1'b1; w1 = 1'b1;
        @(posedge clk); #1; v1 = 1'b0;
        ta_cnt = 0; we_cnt = 0;
        for (int k = 0; k < 10; k++) begin
            if (!ce1 && oe1 && we1) ta_cnt++;
            if (!we1) we_cnt++;
            @(posedge clk); #1;
        end
        check("R8 turnaround 2 cycles", ta_cnt, 2);
        check("R8 strobe 3 cycles", we_cnt, 3);

        // R1: reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00020; req_wdata = 24'h313131;
        @(posedge clk); #1; req_valid = 1'b0;
        rst_n = 1'b0; #1;
        check("R1 reset mid-write", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule